// File: doc/BRIEF.md
# Keyed Configuration Port

This block is the configuration front end of a legacy I/O controller. It sits behind a pair of byte-wide ports on the host I/O bus: an index port at address 0x2E and a data port at 0x2F. After reset the register file is hidden. Only after the host writes the four-byte unlock key 0x87, 0x01, 0x55, 0x55 to the index port does the block accept configuration traffic. In that mode the host writes a register number to the index port and then reads or writes that register through the data port.

Register 0x07 holds a logical device number. The per-device registers are the activate register at 0x30 and the 16-bit base address at 0x60 (high byte) and 0x61 (low byte). They are banked behind that number, so the same register numbers reach a different bank when a different device is selected. Global identity registers give a 16-bit chip identifier and a revision nibble. Writing 0x02 to the index port and then 0x02 to the data port returns the block to the hidden state. The activate bits and base addresses are brought out for the device decoders elsewhere in the chip.

The key sequence is tracked by a five-state machine. The states are SEEK0 (waiting for 0x87), SEEK1 (waiting for 0x01), SEEK2 (waiting for the first 0x55), SEEK3 (waiting for the second 0x55) and OPEN. The transitions are as follows:
- advance: a matching index write moves to the next state, and the last one moves to OPEN.
- restart: a non-matching index write returns to SEEK1 if the byte is 0x87, and otherwise to SEEK0.
- exit: a data write of 0x02 while the index holds 0x02 moves OPEN to SEEK0.
- hold: any other cycle keeps the state.

Top module: `cfg_keyport`

## Requirements
- R1: After reset the block is locked (`cfg_open`=0), every `dev_active` bit is 0, every `dev_base` field is 0, and the logical device number is 0.
- R2: Index-port writes of 0x87, 0x01, 0x55, 0x55 in that order raise `cfg_open` in the cycle after the edge that captures the fourth write. `cfg_open` stays 0 after only three key bytes.
- R3: While locked, an index write that does not match the expected key byte restarts matching. The byte 0x87 counts as the first key byte, and any other wrong byte returns matching to the start. Data-port writes do not change key progress.
- R4: While locked, data-port and index-port reads return 0xFF. Data-port writes are discarded. Index writes are not latched as a register number.
- R5: While open, an index-port write latches the register number, and an index-port read returns it. The register number is 0x00 after reset.
- R6: Register 0x07 holds the logical device number. Registers 0x30, 0x60 and 0x61 act on the bank of the selected device. When the number is not below NUM_DEV, those registers read 0x00 and writes to them are ignored.
- R7: Register 0x20 reads the high byte of CHIP_ID and 0x21 its low byte. Register 0x22 reads {4'h0, CHIP_REV}. Writes to these three registers are ignored.
- R8: Register 0x30 stores bit 0 of the written byte as the device's activate bit and reads back {7'b0, bit}. Bit n of `dev_active` shows device n.
- R9: Registers 0x60 and 0x61 hold the high and low byte of the device base address. `dev_base[16n+15:16n]` shows device n.
- R10: A read of any register number other than 0x07, 0x20, 0x21, 0x22, 0x30, 0x60 or 0x61 returns 0x00.
- R11: While open, writing 0x02 to the data port with the register number 0x02 locks the block and clears the register number to 0x00. Any other value written to register 0x02 leaves the block open. Locking keeps the logical device number and the bank contents.
- R12: Reads are combinational. A read in the same cycle as a write on the same port returns the value from before the write, and the effect of the write is visible from the next cycle.
- R13: Accesses to any I/O address other than the two ports read 0x00 and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | ADDR_W (16) | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid in the same cycle as `io_rd` |
| cfg_open | output | 1 | High while configuration access is unlocked |
| dev_active | output | NUM_DEV | Activate bit of each logical device |
| dev_base | output | 16*NUM_DEV | Base address of each logical device, device n in bits 16n+15:16n |

## Verification
Two of the block's functions can meet in one cycle: a read and a state-changing write on the same port. The first case is a data-port read asserted together with the exit write of 0x02. The second is a data-port read asserted together with a logical device number write. The third is an index-port read asserted with the final key byte. The bench drives `io_rd` and `io_wr` together in one bus cycle. It expects the read to return the value from before the write: 0x00 for register 0x02, the old device number, and 0xFF while the port is still locked. It then reads again in the next cycle and expects the new value.

// File: rtl/cfg_keyport_pkg.sv
package cfg_keyport_pkg;

    typedef enum logic [2:0] {
        ST_SEEK0,
        ST_SEEK1,
        ST_SEEK2,
        ST_SEEK3,
        ST_OPEN
    } key_state_e;

    localparam logic [7:0] KEY_B0 = 8'h87;
    localparam logic [7:0] KEY_B1 = 8'h01;
    localparam logic [7:0] KEY_B2 = 8'h55;
    localparam logic [7:0] KEY_B3 = 8'h55;

    localparam logic [7:0] EXIT_CODE = 8'h02;

    localparam logic [7:0] RN_EXIT    = 8'h02;
    localparam logic [7:0] RN_LDN     = 8'h07;
    localparam logic [7:0] RN_ID_HI   = 8'h20;
    localparam logic [7:0] RN_ID_LO   = 8'h21;
    localparam logic [7:0] RN_REV     = 8'h22;
    localparam logic [7:0] RN_ACT     = 8'h30;
    localparam logic [7:0] RN_BASE_HI = 8'h60;
    localparam logic [7:0] RN_BASE_LO = 8'h61;

    localparam logic [7:0] LOCKED_READ = 8'hFF;

endpackage

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_keyport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic       data_wr,
    input  logic [7:0] wbyte,
    input  logic [7:0] index_q,
    output logic       cfg_open,
    output logic       exit_cmd
);

    key_state_e state_q, state_d;
    logic [7:0] restart_byte_hit;
    key_state_e restart_st;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SEEK0;
        else        state_q <= state_d;
    end

    always_comb begin
        restart_byte_hit = wbyte ^ KEY_B0;
        restart_st = (restart_byte_hit == 8'h00) ? ST_SEEK1 : ST_SEEK0;
        state_d = state_q;
        unique case (state_q)
            ST_SEEK0: if (idx_wr) state_d = restart_st;
            ST_SEEK1: if (idx_wr) state_d = (wbyte == KEY_B1) ? ST_SEEK2 : restart_st;
            ST_SEEK2: if (idx_wr) state_d = (wbyte == KEY_B2) ? ST_SEEK3 : restart_st;
            ST_SEEK3: if (idx_wr) state_d = (wbyte == KEY_B3) ? ST_OPEN  : restart_st;
            ST_OPEN:  if (exit_cmd) state_d = ST_SEEK0;
            default:  state_d = ST_SEEK0;
        endcase
    end

    always_comb begin
        cfg_open = (state_q == ST_OPEN);
        exit_cmd = cfg_open && data_wr && (index_q == RN_EXIT) && (wbyte == EXIT_CODE);
    end

    // R2: configuration mode opens only on the last key byte
    p_open_needs_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(idx_wr && wbyte == KEY_B3));

    // R3: a wrong byte other than the first key byte restarts from the beginning
    p_wrong_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && idx_wr && wbyte != KEY_B0 && wbyte != KEY_B1 && wbyte != KEY_B2)
        |=> (state_q == ST_SEEK0));

    // R11: exit command locks the block
    p_exit_locks_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && data_wr && index_q == RN_EXIT && wbyte == EXIT_CODE) |=> !cfg_open);

endmodule

// File: rtl/cfg_index_reg.sv
module cfg_index_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_open,
    input  logic       idx_wr,
    input  logic       exit_cmd,
    input  logic [7:0] wbyte,
    output logic [7:0] index_q
);

    always_ff @(posedge clk) begin
        if (!rst_n)                  index_q <= 8'h00;
        else if (exit_cmd)           index_q <= 8'h00;
        else if (cfg_open && idx_wr) index_q <= wbyte;
    end

    // R11: register number is cleared after the exit command
    p_index_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        exit_cmd |=> (index_q == 8'h00));

    // R4: index writes while locked are not latched
    p_index_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open) |=> $stable(index_q));

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_keyport_pkg::*;
#(
    parameter int BASE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        reg_num,
    input  logic [7:0]        wbyte,
    output logic              active,
    output logic [BASE_W-1:0] base,
    output logic [7:0]        rd_byte
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            base   <= '0;
        end else if (wr_en) begin
            if (reg_num == RN_ACT)     active <= wbyte[0];
            if (reg_num == RN_BASE_HI) base[BASE_W-1:8] <= wbyte;
            if (reg_num == RN_BASE_LO) base[7:0] <= wbyte;
        end
    end

    always_comb begin
        unique case (reg_num)
            RN_ACT:     rd_byte = {7'b0, active};
            RN_BASE_HI: rd_byte = base[BASE_W-1:8];
            RN_BASE_LO: rd_byte = base[7:0];
            default:    rd_byte = 8'h00;
        endcase
    end

    // R8: the activate bit takes bit 0 of the written byte
    p_act_bit0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_num == RN_ACT) |=> (active == $past(wbyte[0])));

    // R9: a base low-byte write leaves the high byte alone
    p_base_lo_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_num == RN_BASE_LO) |=> (base[BASE_W-1:8] == $past(base[BASE_W-1:8])));

endmodule

// File: rtl/cfg_keyport.sv
module cfg_keyport
    import cfg_keyport_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter int          NUM_DEV    = 4,
    parameter logic [15:0] INDEX_ADDR = 16'h002E,
    parameter logic [15:0] DATA_ADDR  = 16'h002F,
    parameter logic [15:0] CHIP_ID    = 16'hC3A7,
    parameter logic [3:0]  CHIP_REV   = 4'h5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic                  cfg_open,
    output logic [NUM_DEV-1:0]    dev_active,
    output logic [16*NUM_DEV-1:0] dev_base
);

    localparam int BASE_W = 16;
    localparam int IDX_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic       hit_index, hit_data;
    logic       idx_wr, data_wr, cfg_wr;
    logic       exit_cmd;
    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic       ldn_ok;
    logic [IDX_W-1:0] ldn_idx;
    logic [7:0] reg_rd;
    logic [7:0] bank_rd [NUM_DEV];

    assign hit_index = (io_addr == ADDR_W'(INDEX_ADDR));
    assign hit_data  = (io_addr == ADDR_W'(DATA_ADDR));
    assign idx_wr    = io_wr && hit_index;
    assign data_wr   = io_wr && hit_data;
    assign cfg_wr    = cfg_open && data_wr;
    assign ldn_ok    = (ldn_q < 8'(NUM_DEV));
    assign ldn_idx   = ldn_q[IDX_W-1:0];

    cfg_key_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .data_wr  (data_wr),
        .wbyte    (io_wdata),
        .index_q  (index_q),
        .cfg_open (cfg_open),
        .exit_cmd (exit_cmd)
    );

    cfg_index_reg u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_open (cfg_open),
        .idx_wr   (idx_wr),
        .exit_cmd (exit_cmd),
        .wbyte    (io_wdata),
        .index_q  (index_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                           ldn_q <= 8'h00;
        else if (cfg_wr && index_q == RN_LDN) ldn_q <= io_wdata;
    end

    for (genvar n = 0; n < NUM_DEV; n++) begin : g_bank
        logic bank_wr;
        assign bank_wr = cfg_wr && (ldn_q == 8'(n));
        cfg_dev_bank #(.BASE_W(BASE_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bank_wr),
            .reg_num (index_q),
            .wbyte   (io_wdata),
            .active  (dev_active[n]),
            .base    (dev_base[n*BASE_W +: BASE_W]),
            .rd_byte (bank_rd[n])
        );
    end

    always_comb begin
        unique case (index_q)
            RN_LDN:   reg_rd = ldn_q;
            RN_ID_HI: reg_rd = CHIP_ID[15:8];
            RN_ID_LO: reg_rd = CHIP_ID[7:0];
            RN_REV:   reg_rd = {4'h0, CHIP_REV};
            default:  reg_rd = ldn_ok ? bank_rd[ldn_idx] : 8'h00;
        endcase
    end

    always_comb begin
        io_rdata = 8'h00;
        if (io_rd) begin
            if (hit_index)     io_rdata = cfg_open ? index_q : LOCKED_READ;
            else if (hit_data) io_rdata = cfg_open ? reg_rd  : LOCKED_READ;
        end
    end

    // R4: locked data reads return all ones
    p_locked_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && io_rd && hit_data) |-> (io_rdata == LOCKED_READ));

    // R4: nothing in the banks changes while locked
    p_locked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open) |=> ($stable(dev_active) && $stable(dev_base) && $stable(ldn_q)));

    // R6: an out-of-range device number protects every bank
    p_ldn_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ldn_ok) |=> ($stable(dev_active) && $stable(dev_base)));

    // R13: foreign addresses read zero
    p_foreign_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_index && !hit_data) |-> (io_rdata == 8'h00));

endmodule

// File: tb/cfg_keyport_tb.sv
module cfg_keyport_tb;

    localparam int          ADDR_W = 16;
    localparam int          NDEV   = 4;
    localparam logic [15:0] A_IDX  = 16'h002E;
    localparam logic [15:0] A_DAT  = 16'h002F;

    typedef struct packed {
        logic       rd;
        logic       dp;
        logic [7:0] d;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 78;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1,1'b1,8'h00,8'hFF,4'd4},   // R4 locked read
        '{1'b0,1'b1,8'h33,8'h00,4'd4},   // R4 locked write discarded
        '{1'b0,1'b0,8'h87,8'h00,4'd2},   // R2 key
        '{1'b0,1'b0,8'h01,8'h00,4'd2},
        '{1'b0,1'b0,8'h55,8'h00,4'd2},
        '{1'b0,1'b0,8'h55,8'h00,4'd2},
        '{1'b1,1'b0,8'h00,8'h00,4'd5},   // R5 index after reset
        '{1'b0,1'b0,8'h20,8'h00,4'd7},   // R7 id
        '{1'b1,1'b1,8'h00,8'hC3,4'd7},
        '{1'b0,1'b0,8'h21,8'h00,4'd7},
        '{1'b1,1'b1,8'h00,8'hA7,4'd7},
        '{1'b0,1'b0,8'h22,8'h00,4'd7},
        '{1'b1,1'b1,8'h00,8'h05,4'd7},
        '{1'b0,1'b1,8'hFF,8'h00,4'd7},
        '{1'b1,1'b1,8'h00,8'h05,4'd7},
        '{1'b0,1'b0,8'h07,8'h00,4'd6},   // R6 ldn
        '{1'b0,1'b1,8'h01,8'h00,4'd6},
        '{1'b1,1'b1,8'h00,8'h01,4'd6},
        '{1'b0,1'b0,8'h30,8'h00,4'd8},   // R8 activate
        '{1'b0,1'b1,8'h01,8'h00,4'd8},
        '{1'b1,1'b1,8'h00,8'h01,4'd8},
        '{1'b0,1'b1,8'hFF,8'h00,4'd8},
        '{1'b1,1'b1,8'h00,8'h01,4'd8},
        '{1'b0,1'b0,8'h60,8'h00,4'd9},   // R9 base
        '{1'b0,1'b1,8'h12,8'h00,4'd9},
        '{1'b0,1'b0,8'h61,8'h00,4'd9},
        '{1'b0,1'b1,8'h34,8'h00,4'd9},
        '{1'b1,1'b1,8'h00,8'h34,4'd9},
        '{1'b0,1'b0,8'h60,8'h00,4'd9},
        '{1'b1,1'b1,8'h00,8'h12,4'd9},
        '{1'b0,1'b0,8'h07,8'h00,4'd6},   // R6 other bank
        '{1'b0,1'b1,8'h02,8'h00,4'd6},
        '{1'b0,1'b0,8'h60,8'h00,4'd6},
        '{1'b1,1'b1,8'h00,8'h00,4'd6},
        '{1'b0,1'b0,8'h07,8'h00,4'd6},
        '{1'b0,1'b1,8'h01,8'h00,4'd6},
        '{1'b0,1'b0,8'h61,8'h00,4'd6},
        '{1'b1,1'b1,8'h00,8'h34,4'd6},
        '{1'b0,1'b0,8'h07,8'h00,4'd6},   // R6 out of range
        '{1'b0,1'b1,8'h09,8'h00,4'd6},
        '{1'b0,1'b0,8'h30,8'h00,4'd6},
        '{1'b0,1'b1,8'h01,8'h00,4'd6},
        '{1'b1,1'b1,8'h00,8'h00,4'd6},
        '{1'b0,1'b0,8'h07,8'h00,4'd6},
        '{1'b1,1'b1,8'h00,8'h09,4'd6},
        '{1'b0,1'b0,8'h45,8'h00,4'd10},  // R10 unimplemented
        '{1'b1,1'b1,8'h00,8'h00,4'd10},
        '{1'b1,1'b0,8'h00,8'h45,4'd5},   // R5 index readback
        '{1'b0,1'b0,8'h02,8'h00,4'd11},  // R11 exit
        '{1'b0,1'b1,8'h05,8'h00,4'd11},
        '{1'b1,1'b0,8'h00,8'h02,4'd11},
        '{1'b0,1'b1,8'h02,8'h00,4'd11},
        '{1'b1,1'b1,8'h00,8'hFF,4'd11},
        '{1'b1,1'b0,8'h00,8'hFF,4'd11},
        '{1'b0,1'b0,8'h30,8'h00,4'd4},   // R4 locked index write
        '{1'b0,1'b1,8'h00,8'h00,4'd4},
        '{1'b0,1'b0,8'h87,8'h00,4'd3},   // R3 0x87 restarts
        '{1'b0,1'b0,8'h01,8'h00,4'd3},
        '{1'b0,1'b0,8'h87,8'h00,4'd3},
        '{1'b0,1'b0,8'h01,8'h00,4'd3},
        '{1'b0,1'b0,8'h55,8'h00,4'd3},
        '{1'b0,1'b0,8'h55,8'h00,4'd3},
        '{1'b1,1'b0,8'h00,8'h00,4'd3},
        '{1'b0,1'b0,8'h07,8'h00,4'd11},  // R11 ldn kept
        '{1'b1,1'b1,8'h00,8'h09,4'd11},
        '{1'b0,1'b0,8'h02,8'h00,4'd11},
        '{1'b0,1'b1,8'h02,8'h00,4'd11},
        '{1'b0,1'b0,8'h87,8'h00,4'd3},   // R3 broken key
        '{1'b0,1'b0,8'h01,8'h00,4'd3},
        '{1'b0,1'b0,8'h55,8'h00,4'd3},
        '{1'b0,1'b0,8'h54,8'h00,4'd3},
        '{1'b0,1'b0,8'h55,8'h00,4'd3},
        '{1'b1,1'b1,8'h00,8'hFF,4'd3},
        '{1'b0,1'b0,8'h87,8'h00,4'd3},
        '{1'b0,1'b0,8'h01,8'h00,4'd3},
        '{1'b0,1'b0,8'h55,8'h00,4'd3},
        '{1'b0,1'b0,8'h55,8'h00,4'd3},
        '{1'b1,1'b1,8'h00,8'h00,4'd3}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [ADDR_W-1:0]    io_addr = '0;
    logic                 io_wr = 1'b0;
    logic                 io_rd = 1'b0;
    logic [7:0]           io_wdata = 8'h00;
    logic [7:0]           io_rdata;
    logic                 cfg_open;
    logic [NDEV-1:0]      dev_active;
    logic [16*NDEV-1:0]   dev_base;

    int  n_tests = 0;
    int  n_fails = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    cfg_keyport u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_addr    (io_addr),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_wdata   (io_wdata),
        .io_rdata   (io_rdata),
        .cfg_open   (cfg_open),
        .dev_active (dev_active),
        .dev_base   (dev_base)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_cycle(input logic wr, input logic rd, input logic [15:0] addr,
                             input logic [7:0] d, output logic [7:0] got);
        @(negedge clk);
        io_addr  = addr;
        io_wr    = wr;
        io_rd    = rd;
        io_wdata = d;
        #1;
        got = io_rdata;
        @(posedge clk);
        #1;
        io_wr = 1'b0;
        io_rd = 1'b0;
    endtask

    initial begin
        logic [7:0] got;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 cfg_open", 64'(cfg_open), 64'h0);
        check("R1 dev_active", 64'(dev_active), 64'h0);
        check("R1 dev_base", dev_base, 64'h0);

        for (int i = 0; i < NVEC; i++) begin
            bus_cycle(!VECS[i].rd, VECS[i].rd, VECS[i].dp ? A_DAT : A_IDX, VECS[i].d, got);
            if (VECS[i].rd)
                check($sformatf("R%0d vec%0d", VECS[i].req, i), 64'(got), 64'(VECS[i].exp));
        end

        // R8 and R9 at the ports: device 1 active with base 0x1234
        check("R8 dev_active", 64'(dev_active), 64'h2);
        check("R9 dev_base", dev_base, 64'h0000_0000_1234_0000);

        // R12: device number write with same-cycle read returns the old number
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h07, got);
        bus_cycle(1'b1, 1'b1, A_DAT, 8'h01, got);
        check("R12 ldn same-cycle", 64'(got), 64'h09);
        bus_cycle(1'b0, 1'b1, A_DAT, 8'h00, got);
        check("R12 ldn next", 64'(got), 64'h01);

        // R12 / R11: exit write with same-cycle read
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h02, got);
        bus_cycle(1'b1, 1'b1, A_DAT, 8'h02, got);
        check("R12 exit same-cycle", 64'(got), 64'h00);
        check("R11 cfg_open after exit", 64'(cfg_open), 64'h0);
        bus_cycle(1'b0, 1'b1, A_DAT, 8'h00, got);
        check("R12 exit next", 64'(got), 64'hFF);

        // R2: cfg_open timing over the key
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h87, got);
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h01, got);
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h55, got);
        check("R2 three bytes", 64'(cfg_open), 64'h0);
        bus_cycle(1'b1, 1'b1, A_IDX, 8'h55, got);
        check("R12 final key read", 64'(got), 64'hFF);
        check("R2 four bytes", 64'(cfg_open), 64'h1);
        bus_cycle(1'b0, 1'b1, A_IDX, 8'h00, got);
        check("R5 index after key", 64'(got), 64'h00);

        // R3: data writes during the key do not disturb it
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h02, got);
        bus_cycle(1'b1, 1'b0, A_DAT, 8'h02, got);
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h87, got);
        bus_cycle(1'b1, 1'b0, A_DAT, 8'h11, got);
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h01, got);
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h55, got);
        bus_cycle(1'b1, 1'b0, A_IDX, 8'h55, got);
        check("R3 data write during key", 64'(cfg_open), 64'h1);

        // R13: foreign address
        bus_cycle(1'b0, 1'b1, 16'h0080, 8'h00, got);
        check("R13 foreign read", 64'(got), 64'h00);
        bus_cycle(1'b1, 1'b0, 16'h0080, 8'h02, got);
        bus_cycle(1'b1, 1'b0, 16'h002F | 16'h0100, 8'h00, got);
        check("R13 foreign write", 64'(cfg_open), 64'h1);
        check("R13 banks unchanged", dev_base, 64'h0000_0000_1234_0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fails++;
            $display("FAIL R0 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
            $finish;
        end
    end

endmodule